// File: doc/BRIEF.md
# Analog Input Channel-List Controller

This block is the host-facing controller for a multiplexed 12-bit analog input path. It has a 16-bit register map. Software loads a list of conversion descriptors into a small list memory and picks an acquisition mode. Each conversion is then fired by reading the first control register. For each conversion, the block hands the next descriptor to an external converter over a start/done/data handshake, and queues the 12-bit result in a result FIFO.

The list is kept, not consumed. Each trigger converts the entry at a read index. The index advances in push order and wraps to the first entry after the last one. Results leave through the same address that accepts list writes: a write there pushes a descriptor and a read pops a result. A status word shows the FIFO levels and the latched interrupt causes. Any write to that status word clears the causes. A single interrupt line combines the causes with their individual enables and a global enable.

Top module: `adc_list_ctrl`

## Requirements
- R1: After reset, offsets 0x00 and 0x02 read 0x0000 and status (0x04) reads 0x0004. A write to 0x00 or 0x02 stores all 16 bits, and a read of the same offset returns them. Unmapped offsets read 0.
- R2: A write to 0x10 appends the low byte as a list entry: channel [3:0], gain [5:4], unipolar 6, differential 7. The append happens only while the list-enable bit (0x02 bit 9) is set and the list holds fewer than LIST_DEPTH entries. Status bit 1 is set when the list is full. Writes to a full list are dropped.
- R3: A read of 0x00 in software mode (0x00 bits [1:0] = 1) with a non-empty, enabled list and no conversion pending starts a conversion. The block raises `adc_start` for exactly one cycle, on the cycle after the read, and `adc_cfg` carries the entry at the read index. Entries are used in push order and the index wraps to the first entry after the last one.
- R4: A trigger read is ignored in any mode other than 1, with the list empty or disabled, or while a conversion is pending.
- R5: Status bit 0 (active) is set from the trigger until `adc_done` returns.
- R6: `adc_done` during an active conversion stores `adc_data` in the result FIFO, provided the result-enable bit (0x02 bit 10) is set. A read of 0x10 returns the oldest result, zero-extended, and removes it. A read of an empty FIFO returns 0.
- R7: Status bit 2 flags an empty result FIFO, bit 3 flags at least RES_DEPTH/2 results, and bit 4 flags a full one. A result that arrives while the FIFO is full or disabled is dropped, and the full flag stays set.
- R8: Clearing bit 9 of 0x02 empties the list and resets the read index. Clearing bit 10 empties the result FIFO. Both take effect at the same edge as the write.
- R9: Cause bits in status are latched as follows: bit 8 on the rising of the half-full flag, bit 9 on `ev_ext`, bit 10 when the last list entry is triggered, bit 11 on `ev_cnt_a`, bit 12 on `ev_cnt_b`. Any write to 0x04 clears all of them, and the clear wins over a new cause at the same edge.
- R10: `irq` is high exactly when 0x00 bit 15 is set and some cause bit is latched whose enable sits at the same position in 0x00 (bits 12:8).
- R11: A write to 0x00 with mode bits 0 abandons a pending conversion and clears the active flag. Writing zero to 0x00, 0x02 and 0x04 returns status to 0x0004.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (reads have side effects) |
| addr | input | 5 | Byte offset |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for the current offset |
| irq | output | 1 | Interrupt request |
| ev_ext | input | 1 | External event pulse |
| ev_cnt_a | input | 1 | Counter A event pulse |
| ev_cnt_b | input | 1 | Counter B event pulse |
| adc_start | output | 1 | One-cycle conversion start |
| adc_cfg | output | 8 | Descriptor of the conversion being started |
| adc_done | input | 1 | Conversion finished, data valid |
| adc_data | input | 12 | Conversion result |

## Verification
The bench builds the block with LIST_DEPTH = 4 and RES_DEPTH = 8. With a four-entry list, the full flag, the dropped fifth append and the wrap of the read index all show up after a handful of writes and triggers. With eight result slots, the half-full cause, the full flag and a dropped overflow result are reached with about ten conversions. A behavioural queue model runs beside the block and predicts `adc_start`, `adc_cfg` and `irq` on every clock. The same model predicts each register read.

// File: rtl/adc_list_ctrl.sv
module adc_list_ctrl #(
  parameter int LIST_DEPTH = 16,
  parameter int RES_DEPTH  = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic        rd_en,
  input  logic [4:0]  addr,
  input  logic [15:0] wdata,
  output logic [15:0] rdata,
  output logic        irq,
  input  logic        ev_ext,
  input  logic        ev_cnt_a,
  input  logic        ev_cnt_b,
  output logic        adc_start,
  output logic [7:0]  adc_cfg,
  input  logic        adc_done,
  input  logic [11:0] adc_data
);
  localparam int LW  = $clog2(LIST_DEPTH);
  localparam int LCW = $clog2(LIST_DEPTH + 1);
  localparam int RW  = $clog2(RES_DEPTH);
  localparam int RCW = $clog2(RES_DEPTH + 1);
  localparam logic [4:0] A_CTRL1 = 5'h00;
  localparam logic [4:0] A_CTRL2 = 5'h02;
  localparam logic [4:0] A_STAT  = 5'h04;
  localparam logic [4:0] A_DATA  = 5'h10;

  logic [15:0]    c1, c2;
  logic [7:0]     lst [LIST_DEPTH];
  logic [LCW-1:0] lcnt;
  logic [LW-1:0]  lidx;
  logic [11:0]    rmem [RES_DEPTH];
  logic [RW-1:0]  rwp, rrp;
  logic [RCW-1:0] rcnt;
  logic           busy, hf_q, start_q;
  logic [7:0]     cfg_q;
  logic [4:0]     cause;

  wire wr_c1 = wr_en && addr == A_CTRL1;
  wire wr_c2 = wr_en && addr == A_CTRL2;
  wire wr_st = wr_en && addr == A_STAT;
  wire wr_dt = wr_en && addr == A_DATA;
  wire rd_c1 = rd_en && addr == A_CTRL1;
  wire rd_dt = rd_en && addr == A_DATA;

  wire l_en_n = wr_c2 ? wdata[9]  : c2[9];
  wire r_en_n = wr_c2 ? wdata[10] : c2[10];
  wire l_full = lcnt == LCW'(LIST_DEPTH);
  wire r_full = rcnt == RCW'(RES_DEPTH);
  wire r_empty = rcnt == '0;
  wire hf = rcnt >= RCW'(RES_DEPTH / 2);
  wire trig = rd_c1 && c1[1:0] == 2'd1 && c2[9] && lcnt != '0 && !busy;
  wire last = LCW'(lidx) + LCW'(1) == lcnt;
  wire lpush = wr_dt && c2[9] && !l_full;
  wire rpush = adc_done && busy && c2[10] && !r_full;
  wire rpop = rd_dt && !r_empty;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      c1 <= '0;
      c2 <= '0;
    end else begin
      if (wr_c1) c1 <= wdata;
      if (wr_c2) c2 <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !l_en_n) begin
      lcnt <= '0;
      lidx <= '0;
    end else begin
      if (lpush) lcnt <= lcnt + LCW'(1);
      if (trig) lidx <= last ? '0 : lidx + LW'(1);
    end
  end

  always_ff @(posedge clk)
    if (lpush) lst[lcnt[LW-1:0]] <= wdata[7:0];

  always_ff @(posedge clk) begin
    if (!rst_n || !r_en_n) begin
      rwp  <= '0;
      rrp  <= '0;
      rcnt <= '0;
    end else begin
      if (rpush) rwp <= (rwp == RW'(RES_DEPTH - 1)) ? '0 : rwp + RW'(1);
      if (rpop)  rrp <= (rrp == RW'(RES_DEPTH - 1)) ? '0 : rrp + RW'(1);
      rcnt <= rcnt + RCW'(rpush) - RCW'(rpop);
    end
  end

  always_ff @(posedge clk)
    if (rpush) rmem[rwp] <= adc_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      start_q <= 1'b0;
      cfg_q   <= '0;
      hf_q    <= 1'b0;
      cause   <= '0;
    end else begin
      if (wr_c1 && wdata[1:0] == 2'd0) busy <= 1'b0;
      else if (trig)                   busy <= 1'b1;
      else if (adc_done)               busy <= 1'b0;
      start_q <= trig;
      if (trig) cfg_q <= lst[lidx];
      hf_q <= hf;
      if (wr_st) cause <= '0;
      else cause <= cause | {ev_cnt_b, ev_cnt_a, trig && last, ev_ext, hf && !hf_q};
    end
  end

  wire [15:0] status = {3'b000, cause, 3'b000, r_full, hf, r_empty, l_full, busy};

  always_comb begin
    case (addr)
      A_CTRL1: rdata = c1;
      A_CTRL2: rdata = c2;
      A_STAT:  rdata = status;
      A_DATA:  rdata = r_empty ? 16'h0000 : {4'h0, rmem[rrp]};
      default: rdata = 16'h0000;
    endcase
  end

  assign irq       = c1[15] && |(cause & c1[12:8]);
  assign adc_start = start_q;
  assign adc_cfg   = cfg_q;

  AST_EMPTY_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_c1 && lcnt == '0) |=> !adc_start); // R4
  AST_START_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    adc_start |-> status[0]); // R5
  AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (r_full && !rd_dt && !wr_c2) |=> r_full); // R7
  AST_CAUSE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    wr_st |=> cause == 5'd0); // R9
  AST_ABANDON_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_c1 && wdata[1:0] == 2'd0) |=> !busy); // R11
endmodule

// File: tb/sim_adc_list_ctrl.sv
module sim_adc_list_ctrl;
  localparam int LD = 4;
  localparam int RD = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [4:0] addr = '0;
  logic [15:0] wdata = '0;
  logic ev_ext = 1'b0, ev_cnt_a = 1'b0, ev_cnt_b = 1'b0;
  logic adc_done = 1'b0;
  logic [11:0] adc_data = '0;
  logic [15:0] rdata;
  logic irq, adc_start;
  logic [7:0] adc_cfg;

  always #4 clk = ~clk;

  adc_list_ctrl #(.LIST_DEPTH(LD), .RES_DEPTH(RD)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .irq(irq), .ev_ext(ev_ext),
    .ev_cnt_a(ev_cnt_a), .ev_cnt_b(ev_cnt_b), .adc_start(adc_start),
    .adc_cfg(adc_cfg), .adc_done(adc_done), .adc_data(adc_data));

  int checks = 0, fails = 0;

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // reference model
  logic [15:0] m_c1, m_c2;
  int lq[$];
  int rq[$];
  int lidx, m_entry, ln, rsz;
  bit m_busy, m_hfp, m_start, hf, trig, wrap, l_en, r_en;
  bit [4:0] m_cause;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_c1 = 0; m_c2 = 0; lq.delete(); rq.delete(); lidx = 0;
      m_busy = 0; m_hfp = 0; m_start = 0; m_cause = 0; m_entry = 0;
    end else begin
      ln = lq.size();
      rsz = rq.size();
      hf = rsz >= RD / 2;
      trig = rd_en && addr == 5'h00 && m_c1[1:0] == 2'd1 && m_c2[9] && ln > 0 && !m_busy;
      wrap = 0;
      m_start = trig;
      if (trig) begin
        m_entry = lq[lidx];
        wrap = (lidx + 1 == ln);
        lidx = wrap ? 0 : lidx + 1;
      end
      if (adc_done && m_busy && m_c2[10] && rsz < RD) rq.push_back(int'(adc_data));
      if (rd_en && addr == 5'h10 && rsz > 0) void'(rq.pop_front());
      if (wr_en && addr == 5'h10 && m_c2[9] && ln < LD) lq.push_back(int'(wdata[7:0]));
      if (wr_en && addr == 5'h00 && wdata[1:0] == 2'd0) m_busy = 0;
      else if (trig) m_busy = 1;
      else if (adc_done) m_busy = 0;
      if (wr_en && addr == 5'h04) m_cause = 0;
      else m_cause |= {ev_cnt_b, ev_cnt_a, wrap, ev_ext, hf && !m_hfp};
      m_hfp = hf;
      l_en = (wr_en && addr == 5'h02) ? wdata[9] : m_c2[9];
      r_en = (wr_en && addr == 5'h02) ? wdata[10] : m_c2[10];
      if (wr_en && addr == 5'h00) m_c1 = wdata;
      if (wr_en && addr == 5'h02) m_c2 = wdata;
      if (!l_en) begin lq.delete(); lidx = 0; end
      if (!r_en) rq.delete();
    end
  end

  function automatic int exp_rd(logic [4:0] a);
    case (a)
      5'h00: return int'(m_c1);
      5'h02: return int'(m_c2);
      5'h04: return (int'(m_cause) << 8) | ((rq.size() == RD) << 4) |
                    ((rq.size() >= RD / 2) << 3) | ((rq.size() == 0) << 2) |
                    ((lq.size() == LD) << 1) | int'(m_busy);
      5'h10: return rq.size() > 0 ? rq[0] : 0;
      default: return 0;
    endcase
  endfunction

  // per-clock comparison of the outputs
  always @(negedge clk) if (rst_n) begin
    chk("R3 adc_start", int'(adc_start), int'(m_start));
    if (m_start) chk("R3 adc_cfg", int'(adc_cfg), m_entry);
    chk("R10 irq", int'(irq), int'(m_c1[15] && ((m_cause & m_c1[12:8]) != 0)));
  end

  // converter model
  int adc_cnt = 0, seq = 0;
  bit adc_hold = 0;
  logic [3:0] adc_ch = '0;
  always @(negedge clk) begin
    adc_done <= 1'b0;
    if (adc_start) begin
      adc_cnt <= 3;
      adc_ch <= adc_cfg[3:0];
    end else if (adc_cnt == 1) begin
      if (!adc_hold) begin
        adc_done <= 1'b1;
        adc_data <= {adc_ch, seq[7:0]};
        seq <= seq + 1;
        adc_cnt <= 0;
      end
    end else if (adc_cnt > 1) adc_cnt <= adc_cnt - 1;
  end

  task automatic wr(logic [4:0] a, logic [15:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(posedge clk); #1 wr_en = 0;
  endtask

  task automatic rd(logic [4:0] a, string tag);
    @(negedge clk); rd_en = 1; addr = a;
    #1 chk(tag, int'(rdata), exp_rd(a));
    @(posedge clk); #1 rd_en = 0;
  endtask

  task automatic ev(bit e, bit a, bit b);
    @(negedge clk); ev_ext = e; ev_cnt_a = a; ev_cnt_b = b;
    @(posedge clk); #1 ev_ext = 0; ev_cnt_a = 0; ev_cnt_b = 0;
  endtask

  task automatic conv(string tag);
    rd(5'h00, tag);
    repeat (6) @(negedge clk);
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #800000;
    fails++;
    $display("FAIL R3 watchdog actual=running expected=finished");
    summary();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    rd(5'h00, "R1 ctrl1 reset");
    rd(5'h02, "R1 ctrl2 reset");
    rd(5'h04, "R1 status reset");
    rd(5'h08, "R1 unmapped");
    wr(5'h10, 16'h0003);                 // list disabled: dropped
    wr(5'h02, 16'h0600);
    wr(5'h00, 16'h0001);
    rd(5'h02, "R1 ctrl2 readback");
    conv("R4 trigger with empty list");
    rd(5'h04, "R4 status empty list");
    wr(5'h10, 16'h0005);
    wr(5'h10, 16'h0093);
    wr(5'h10, 16'h006A);
    rd(5'h04, "R2 not yet full");
    wr(5'h10, 16'h001F);
    rd(5'h04, "R2 list full");
    wr(5'h10, 16'h0042);                 // dropped
    rd(5'h00, "R3 trigger");
    rd(5'h04, "R5 active while pending");
    rd(5'h00, "R4 trigger while pending");
    repeat (6) @(negedge clk);
    rd(5'h04, "R5 idle after done");
    for (int i = 0; i < 5; i++) conv("R3 list order and wrap");
    rd(5'h04, "R7 half-full status");
    for (int i = 0; i < 4; i++) conv("R7 fill");
    rd(5'h04, "R7 full status");
    for (int i = 0; i < 3; i++) rd(5'h10, "R6 pop in order");
    for (int i = 0; i < 6; i++) rd(5'h10, "R6 pop to empty");
    rd(5'h10, "R6 empty read");
    rd(5'h04, "R9 causes latched");
    wr(5'h00, 16'h9F01);
    rd(5'h04, "R10 status before events");
    ev(1, 0, 0);
    ev(0, 1, 1);
    rd(5'h04, "R9 event causes");
    wr(5'h04, 16'h0000);
    rd(5'h04, "R9 cleared by write");
    wr(5'h00, 16'h8201);
    ev(1, 1, 0);
    rd(5'h04, "R10 masked cause");
    wr(5'h04, 16'h1234);
    wr(5'h00, 16'h0002);
    conv("R4 scan mode ignores read");
    wr(5'h00, 16'h0001);
    wr(5'h02, 16'h0400);
    rd(5'h04, "R8 list cleared");
    conv("R4 list disabled");
    wr(5'h02, 16'h0600);
    wr(5'h10, 16'h0007);
    conv("R8 list restarts at first entry");
    rd(5'h04, "R6 one result");
    wr(5'h02, 16'h0200);
    rd(5'h04, "R8 result FIFO cleared");
    conv("R7 result dropped while disabled");
    rd(5'h04, "R7 still empty");
    wr(5'h02, 16'h0600);
    adc_hold = 1;
    rd(5'h00, "R11 trigger held");
    repeat (2) @(negedge clk);
    rd(5'h04, "R11 active before abandon");
    wr(5'h00, 16'h0000);
    rd(5'h04, "R11 abandoned");
    adc_hold = 0;
    repeat (4) @(negedge clk);
    rd(5'h04, "R11 late done ignored");
    wr(5'h02, 16'h0000);
    wr(5'h04, 16'h0000);
    rd(5'h04, "R11 idle status");
    summary();
  end
endmodule